// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the serial configuration port of a larger device. It watches a two-wire serial bus (a clock line and an open-drain data line), recognises start and stop conditions, and answers one of two 7-bit device addresses; a pin chooses which one. A host first sends a register index, then streams data bytes. The index advances by one after every byte, so a whole group of registers can be loaded or fetched in a single transfer.

The register space is split by direction. Indices 0x00 to 0x1F accept writes only, and indices 0x20 to 0x2D can only be read. The slave refuses to acknowledge when a transfer's direction does not suit the register it would touch. Configuration writes appear on a parallel strobe port. Status reads are fetched from a parallel read port. The one exception is index 0x20, which returns a bank of sticky event flags held inside the block. Writing ones to index 0x1F clears the matching flags.

Both bus lines pass through a two-stage synchroniser and a three-sample agreement filter before edge detection. This suits a system clock far faster than the 100 kHz bus clock.

Top module: `twr_reg_slave`

## Requirements
- R1: The slave acknowledges device address 7'b1000001 when `addr_sel` is 0 and 7'b1000011 when `addr_sel` is 1. For any other address it never pulls SDA low before the next start or stop.
- R2: In a write transfer (R/W bit 0), the byte after the device address is the register index. Each following data byte aimed at index 0x00..0x1E produces a single-cycle `wr_en` pulse carrying that index and byte, and the index then advances by one.
- R3: The index byte is acknowledged only when it is 0x2D or below. Otherwise the slave answers NACK and ignores the bus until the next start or stop.
- R4: A write data byte is acknowledged only when the current index is 0x1F or below. At index 0x20 or above the slave answers NACK and raises no write strobe.
- R5: A read transfer (R/W bit 1) is acknowledged only when the current index lies in 0x20..0x2D. Otherwise the slave answers NACK and drives nothing.
- R6: Read data leaves MSB first. The byte for index p is the internal flag bank when p is 0x20, `rd_data` (with `rd_addr` equal to p) for 0x21..0x2D, and 0xFF above 0x2D. The index advances after every byte. When the master answers NACK, SDA is released and stays released.
- R7: The slave begins pulling SDA low only while the filtered SCL is low.
- R8: A pulse on SCL that lasts fewer than three system clocks after synchronisation has no effect on the received bits.
- R9: A stop condition anywhere returns the slave to idle and releases SDA. A start condition anywhere begins a new device-address phase. In both cases a partly received byte is dropped without a write, and the register index is kept across a repeated start.
- R10: Each bit of `flag_set` sets a sticky flag, and a set wins over a clear in the same cycle. A data byte written to index 0x1F clears the flags whose bits are 1 in that byte, and it does not raise `wr_en`.
- R11: After reset, SDA is released, `wr_en` is low and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 1 | Chooses between the two device addresses |
| wr_en | output | 1 | Single-cycle configuration write strobe |
| wr_addr | output | 8 | Register index of the write |
| wr_data | output | 8 | Data byte of the write |
| rd_addr | output | 8 | Current register index for status reads |
| rd_data | input | 8 | Status value for `rd_addr` |
| flag_set | input | 8 | Per-bit pulses that set sticky flags |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a three-sample filter, and the 0x00..0x1F / 0x20..0x2D register split. Because the map is this small, one burst covers every write index plus the first read-only index. A single read burst then covers the whole status range and two bytes beyond it. A sweep covers all 128 device addresses with the select pin low, and each probe's expected acknowledge is computed arithmetically. The bench's bus phases last ten system clocks, which brings glitch rejection, mid-byte aborts and repeated starts within reach next to the filter latency.

// File: rtl/twr_pkg.sv
package twr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_ACK  = 3'd2,
        ST_TX   = 3'd3,
        ST_MACK = 3'd4,
        ST_WAIT = 3'd5
    } st_e;

    typedef enum logic [1:0] {
        RL_DEV  = 2'd0,
        RL_SUB  = 2'd1,
        RL_DATA = 2'd2
    } role_e;
endpackage

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_DEPTH-1:0]  hist;
        logic                   filt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_i};
        d.hist = {q.hist[FILT_DEPTH-2:0], q.sync[SYNC_STAGES-1]};
        if (&q.hist) begin
            d.filt = 1'b1;
        end else if (~|q.hist) begin
            d.filt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign filt_o = q.filt;
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic scl;
        logic sda;
    } ev_t;

    ev_t q, d;

    always_comb begin
        d.scl = scl;
        d.sda = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_rise = scl & ~q.scl;
    assign scl_fall = ~scl & q.scl;
    assign start_ev = scl & q.scl & q.sda & ~sda;
    assign stop_ev  = scl & q.scl & ~q.sda & sda;
endmodule

// File: rtl/twr_slave_fsm.sv
module twr_slave_fsm
    import twr_pkg::*;
#(
    parameter logic [6:0]        DEV_BASE = 7'b1000001,
    parameter int                SEL_BIT  = 1,
    parameter logic [BYTE_W-1:0] WO_LAST  = 8'h1F,
    parameter logic [BYTE_W-1:0] RO_FIRST = 8'h20,
    parameter logic [BYTE_W-1:0] RO_LAST  = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] flag_set,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] flags_o
);
    localparam logic [6:0]        SEL_MASK = 7'b1 << SEL_BIT;
    localparam logic [BYTE_W-1:0] CLR_REG  = WO_LAST;
    localparam logic [BYTE_W-1:0] FLAG_REG = RO_FIRST;

    typedef struct packed {
        st_e               st;
        role_e             role;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              rw;
        logic              oe;
        logic [BYTE_W-1:0] flags;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } fsm_t;

    fsm_t q, d;

    logic [6:0]        dev;
    logic              ro_hit;
    logic              ack;
    logic [BYTE_W-1:0] clr;
    logic [BYTE_W-1:0] tx_val;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        ack     = 1'b0;
        clr     = '0;
        dev     = DEV_BASE | (addr_sel ? SEL_MASK : 7'b0);
        ro_hit  = (q.ptr >= RO_FIRST) && (q.ptr <= RO_LAST);
        tx_val  = !ro_hit ? '1 : ((q.ptr == FLAG_REG) ? q.flags : rd_data);

        if (stop_ev) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_ev) begin
            d.st   = ST_RX;
            d.role = RL_DEV;
            d.oe   = 1'b0;
            d.cnt  = '0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        case (q.role)
                            RL_DEV: begin
                                if (q.sh[7:1] == dev) begin
                                    d.rw = q.sh[0];
                                    ack  = !q.sh[0] || ro_hit;
                                end
                            end
                            RL_SUB: begin
                                if (q.sh <= RO_LAST) begin
                                    ack   = 1'b1;
                                    d.ptr = q.sh;
                                end
                            end
                            default: begin
                                if (q.ptr <= WO_LAST) begin
                                    ack   = 1'b1;
                                    d.ptr = q.ptr + 8'd1;
                                    if (q.ptr == CLR_REG) begin
                                        clr = q.sh;
                                    end else begin
                                        d.wr_en   = 1'b1;
                                        d.wr_addr = q.ptr;
                                        d.wr_data = q.sh;
                                    end
                                end
                            end
                        endcase
                        d.st  = ack ? ST_ACK : ST_WAIT;
                        d.oe  = ack;
                        d.cnt = '0;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.role == RL_DEV && q.rw) begin
                            d.st = ST_TX;
                            d.sh = tx_val;
                            d.oe = ~tx_val[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.oe   = 1'b0;
                            d.role = (q.role == RL_DEV) ? RL_SUB : RL_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st  = ST_MACK;
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.ptr = q.ptr + 8'd1;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b1};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda) begin
                            d.st = ST_WAIT;
                        end else begin
                            d.cnt = 4'd1;
                        end
                    end else if (scl_fall && q.cnt == 4'd1) begin
                        d.st  = ST_TX;
                        d.sh  = tx_val;
                        d.oe  = ~tx_val[BYTE_W-1];
                        d.cnt = '0;
                    end
                end
                default: ;
            endcase
        end

        d.flags = (q.flags & ~clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_addr = q.ptr;
    assign flags_o = q.flags;
endmodule

// File: rtl/twr_reg_slave.sv
module twr_reg_slave
    import twr_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                FILT_DEPTH  = 3,
    parameter logic [6:0]        DEV_BASE    = 7'b1000001,
    parameter int                SEL_BIT     = 1,
    parameter logic [BYTE_W-1:0] WO_LAST     = 8'h1F,
    parameter logic [BYTE_W-1:0] RO_FIRST    = 8'h20,
    parameter logic [BYTE_W-1:0] RO_LAST     = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] flag_set
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] flt_lines;
    logic               scl_flt, sda_flt;
    logic               scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0]  flags_w;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twr_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_DEPTH (FILT_DEPTH)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .filt_o(flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[0];
    assign sda_flt = flt_lines[1];

    twr_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_flt),
        .sda     (sda_flt),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    twr_slave_fsm #(
        .DEV_BASE(DEV_BASE),
        .SEL_BIT (SEL_BIT),
        .WO_LAST (WO_LAST),
        .RO_FIRST(RO_FIRST),
        .RO_LAST (RO_LAST)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda     (sda_flt),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .addr_sel(addr_sel),
        .rd_data (rd_data),
        .flag_set(flag_set),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flags_o (flags_w)
    );
endmodule

// File: rtl/twr_reg_slave_chk.sv
module twr_reg_slave_chk #(
    parameter logic [7:0] CLR_REG = 8'h1F
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_flt,
    input logic       stop_ev,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] flag_set,
    input logic [7:0] flags
);
    assert_drive_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_flt);

    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_no_wr_at_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < CLR_REG));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != 8'd0) |=> ((flags & $past(flag_set)) == $past(flag_set)));
endmodule

bind twr_reg_slave twr_reg_slave_chk #(.CLR_REG(WO_LAST)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .scl_flt (scl_flt),
    .stop_ev (stop_ev),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .flag_set(flag_set),
    .flags   (flags_w)
);

// File: tb/twr_reg_slave_test.sv
`timescale 1ns/1ps
module twr_reg_slave_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] flag_set = 8'd0;
    logic       sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int wcnt = 0;
    int viol = 0;
    logic done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] wlog_a [0:63];
    logic [7:0] wlog_d [0:63];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = rd_addr ^ 8'hA5;

    twr_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .flag_set(flag_set)
    );

    always @(negedge clk) begin
        if (wr_en && wcnt < 64) begin
            wlog_a[wcnt] = wr_addr;
            wlog_d[wcnt] = wr_data;
        end
        if (wr_en) wcnt = wcnt + 1;
        if (sda_oe && !prev_oe && scl_m) viol = viol + 1;
        prev_oe = sda_oe;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_clk(Q);
        scl_m = 1'b1; wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        b = sda_line; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bstart();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic byte_out(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic byte_in(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!mack);
    endtask

    // Write transfer header: start, device write address, index byte.
    task automatic wr_head(input logic [7:0] idx, output logic ack_dev, output logic ack_idx);
        bstart();
        byte_out(8'h82, ack_dev);
        byte_out(idx, ack_idx);
    endtask

    initial begin
        logic a0, a1, a2;
        logic [7:0] v, exp_v;
        int snap;

        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);
        check(sda_oe == 1'b0, "R11 sda released after reset", 32'(sda_oe), 0);
        check(wr_en == 1'b0, "R11 no strobe after reset", 32'(wr_en), 0);

        // R1: address sweep with select low
        for (int a = 0; a < 128; a++) begin
            bstart();
            byte_out({7'(a), 1'b0}, a0);
            bstop();
            check(a0 == (a == 'h41), "R1 address match sel=0", 32'(a0), 32'(a == 'h41));
        end
        addr_sel = 1'b1;
        bstart(); byte_out(8'h82, a0); bstop();
        check(a0 == 1'b0, "R1 base address refused sel=1", 32'(a0), 0);
        bstart(); byte_out(8'h86, a0); bstop();
        check(a0 == 1'b1, "R1 alternate address sel=1", 32'(a0), 1);
        addr_sel = 1'b0;
        check(wcnt == 0, "R1 no writes during probes", 32'(wcnt), 0);

        // R2/R4: full write burst over the write-only range
        wr_head(8'h00, a0, a1);
        check(a0 && a1, "R2 header acknowledged", {a0, a1}, 2'b11);
        for (int i = 0; i < 32; i++) begin
            byte_out(8'(i * 7 + 3), a2);
            check(a2, "R2 data byte acknowledged", 32'(a2), 1);
        end
        byte_out(8'h55, a2);
        check(!a2, "R4 write at read-only index refused", 32'(a2), 0);
        bstop();
        check(wcnt == 31, "R2 strobe count", 32'(wcnt), 31);
        for (int i = 0; i < 31; i++) begin
            check(wlog_a[i] == 8'(i), "R2 auto-increment index", 32'(wlog_a[i]), 32'(i));
            check(wlog_d[i] == 8'(i * 7 + 3), "R2 data byte", 32'(wlog_d[i]), 32'(8'(i * 7 + 3)));
        end

        // R3: index range
        wr_head(8'h2E, a0, a1); bstop();
        check(!a1, "R3 index 0x2E refused", 32'(a1), 0);
        wr_head(8'h2D, a0, a1); bstop();
        check(a1, "R3 index 0x2D accepted", 32'(a1), 1);
        wr_head(8'hFF, a0, a1); bstop();
        check(!a1, "R3 index 0xFF refused", 32'(a1), 0);

        // R5: read at write-only index
        wr_head(8'h05, a0, a1);
        bstart(); byte_out(8'h83, a2);
        check(!a2, "R5 read at write-only index refused", 32'(a2), 0);
        check(sda_oe == 1'b0, "R5 bus released", 32'(sda_oe), 0);
        bstop();

        // R10/R6: flags then full read burst with overrun
        @(negedge clk) flag_set = 8'h3C;
        @(negedge clk) flag_set = 8'h00;
        wr_head(8'h20, a0, a1);
        bstart(); byte_out(8'h83, a2);
        check(a2, "R5 read at status index accepted", 32'(a2), 1);
        for (int i = 0; i < 16; i++) begin
            byte_in(v, i < 15);
            if (i == 0) exp_v = 8'h3C;
            else if (i <= 13) exp_v = 8'(8'h20 + i) ^ 8'hA5;
            else exp_v = 8'hFF;
            check(v == exp_v, "R6 read byte", 32'(v), 32'(exp_v));
        end
        wait_clk(Q);
        check(sda_oe == 1'b0, "R6 released after master NACK", 32'(sda_oe), 0);
        bstop();

        snap = wcnt;
        wr_head(8'h1F, a0, a1);
        byte_out(8'h14, a2);
        bstop();
        check(a2, "R10 clear byte acknowledged", 32'(a2), 1);
        check(wcnt == snap, "R10 no strobe for clear index", 32'(wcnt), 32'(snap));
        wr_head(8'h20, a0, a1);
        bstart(); byte_out(8'h83, a2);
        byte_in(v, 1'b0);
        bstop();
        check(v == 8'h28, "R10 flags after clear", 32'(v), 32'h28);

        // R9: stop and start in the middle of a byte
        snap = wcnt;
        wr_head(8'h03, a0, a1);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bstop();
        check(wcnt == snap, "R9 stop mid-byte drops data", 32'(wcnt), 32'(snap));
        wr_head(8'h10, a0, a1);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bstart();
        byte_out(8'h82, a0);
        check(a0, "R9 address after mid-byte start", 32'(a0), 1);
        byte_out(8'h11, a1);
        byte_out(8'h6B, a2);
        bstop();
        check(wcnt == snap + 1, "R9 single write after restart", 32'(wcnt), 32'(snap + 1));
        check(wlog_a[snap] == 8'h11 && wlog_d[snap] == 8'h6B, "R9 write target",
              {wlog_a[snap], wlog_d[snap]}, 32'h116B);

        // R8: short SCL glitch during a data bit
        snap = wcnt;
        wr_head(8'h07, a0, a1);
        for (int i = 7; i >= 0; i--) begin
            if (i == 3) begin
                sda_m = 1'b0; wait_clk(3);
                scl_m = 1'b1; wait_clk(2);
                scl_m = 1'b0; wait_clk(Q - 5);
                scl_m = 1'b1; wait_clk(2 * Q);
                scl_m = 1'b0; wait_clk(Q);
            end else begin
                bit_out(8'h96 >> i);
            end
        end
        bit_in(a2);
        bstop();
        check(wcnt == snap + 1 && wlog_d[snap] == 8'h96 && wlog_a[snap] == 8'h07,
              "R8 glitch rejected", {wlog_a[snap], wlog_d[snap]}, 32'h0796);

        check(viol == 0, "R7 drive starts only with SCL low", 32'(viol), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule